// File: doc/BRIEF.md
# Cache-control and state-save group decoder

This block sits in an instruction front end after the opcode bytes of one two-byte group have been recognised. Each cycle in which `in_valid` is high, it takes the operand-form byte that follows the opcode, the prefixes seen on the instruction, the feature-enable bits and three control flags. From these it picks one of eleven operations: state save and restore, control/status register load and store, cache-line write-back, two flavours of line flush, a persistence commit, and load, full and store fences. It also decides whether the instruction faults as an undefined opcode or as an unavailable execution unit.

It looks at the whole form byte in a single step rather than through nested field tests. Each encoding carries its own prefix, feature and flag rules, and the priority between the two faults is fixed per encoding. The result is registered and comes out one cycle later behind a one-cycle `out_valid` strobe, with a flag that tells the address-generation stage whether a memory operand must be computed. Address generation, the memory access and the operation itself belong to later stages.

Top module: `grp_legal_dec`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. The other outputs carry that decode in the same cycle. While `rst_n` is low, `out_valid`, `out_op`, `out_need_addr`, `out_ud` and `out_nm` are all 0.
- R2: Form byte bits 7:6 are the mode field: mode 3 selects a register form and any other value a memory form. Bits 5:3 select the operation. `in_pfx` bits are {repne, rep, operand-size, lock} from bit 3 down to bit 0. `in_feat` bits from 0 to 5 enable state-save, write-back, optimised flush, flush, commit and fences. `in_ctl` bits from 0 to 2 are emulate, task-switched and extended-state-enable. `out_op` is one-hot with bit 0 save, 1 restore, 2 CSR load, 3 CSR store, 4 write-back, 5 flush, 6 optimised flush, 7 commit, 8 load fence, 9 full fence and 10 store fence. When a fault is reported, `out_op` is 0 and `out_need_addr` is 0. At most one of `out_ud` and `out_nm` is set.
- R3: Memory forms with select 0 (save) and 1 (restore) raise `out_ud` when the state-save feature is off or lock is present. Otherwise they raise `out_nm` when emulate or task-switched is set.
- R4: Memory forms with select 2 (CSR load) and 3 (CSR store) raise `out_ud` when emulate is set or extended-state-enable is clear. Otherwise they raise `out_nm` when task-switched is set. The lock prefix has no effect on these forms.
- R5: A memory form with select 6 raises `out_ud` when lock is present or operand-size is absent. With operand-size it decodes as write-back, which raises `out_ud` when the write-back feature is off.
- R6: A memory form with select 7 raises `out_ud` on lock. With operand-size it is the optimised flush, which needs its feature. Without operand-size it is the plain flush, which raises `out_ud` when rep or repne is present or the flush feature is off.
- R7: Register form bytes E8–EF decode as load fence, F0–F7 as full fence and F8–FF as store fence. Each raises `out_ud` when the fence feature is off or lock is present.
- R8: Byte F8 with operand-size decodes as commit. It raises `out_ud` when the commit feature is off or lock is present. Without operand-size, F8 follows R7.
- R9: Register form bytes C0–E7, and memory forms with select 4 or 5, always raise `out_ud`.
- R10: `out_need_addr` is 1 exactly when a memory form decodes without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode request strobe |
| in_modrm | input | 8 | Operand-form byte following the opcode |
| in_pfx | input | 4 | Prefix flags {repne, rep, operand-size, lock} |
| in_feat | input | 6 | Feature enables |
| in_ctl | input | 3 | Control flags {ext-state-enable, task-switched, emulate} |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_op | output | 11 | One-hot operation, 0 on fault |
| out_need_addr | output | 1 | A memory operand address must be computed |
| out_ud | output | 1 | Undefined-opcode fault |
| out_nm | output | 1 | Unit-unavailable fault |

## Verification
The block keeps no state between requests except the output register. A wrong decode therefore shows at the ports in the very next cycle, as a wrong one-hot bit, a fault of the wrong kind, or an address request on a faulting or register form. A stuck or mistimed valid register shows as `out_valid` missing, lasting too long or arriving a cycle late. The stimulus sweeps every form byte against every prefix combination and every control-flag setting, then adds random requests with features dropped and idle gaps mixed in. Each result is compared against a behavioural model on every clock.

// File: rtl/grp_dec_pkg.sv
package grp_dec_pkg;

  localparam int OP_W    = 11;
  localparam int PFX_W   = 4;
  localparam int FEAT_W  = 6;
  localparam int CTL_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 3;

  // one-hot operation positions
  localparam int OP_SAVE    = 0;
  localparam int OP_RESTORE = 1;
  localparam int OP_CSR_LD  = 2;
  localparam int OP_CSR_ST  = 3;
  localparam int OP_WBACK   = 4;
  localparam int OP_FLUSH   = 5;
  localparam int OP_FLOPT   = 6;
  localparam int OP_COMMIT  = 7;
  localparam int OP_LFENCE  = 8;
  localparam int OP_MFENCE  = 9;
  localparam int OP_SFENCE  = 10;

  localparam int MEM_OPS = OP_FLOPT + 1;
  localparam logic [OP_W-1:0] MEM_OP_MASK = OP_W'((1 << MEM_OPS) - 1);

  // prefix vector positions
  localparam int PFX_LOCK  = 0;
  localparam int PFX_OPSZ  = 1;
  localparam int PFX_REP   = 2;
  localparam int PFX_REPNE = 3;

  // feature positions
  localparam int FT_SAVE   = 0;
  localparam int FT_WBACK  = 1;
  localparam int FT_FLOPT  = 2;
  localparam int FT_FLUSH  = 3;
  localparam int FT_COMMIT = 4;
  localparam int FT_FENCE  = 5;

  // control flag positions
  localparam int CT_EMU  = 0;
  localparam int CT_TS   = 1;
  localparam int CT_XEN  = 2;

  typedef enum logic [1:0] {
    RF_RSV    = 2'd0,
    RF_LFENCE = 2'd1,
    RF_MFENCE = 2'd2,
    RF_SFENCE = 2'd3
  } reg_cls_e;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic            need_addr;
    logic            ud;
    logic            nm;
  } dec_res_t;

endpackage

// File: rtl/grp_form_split.sv
module grp_form_split
  import grp_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] modrm,
  output logic              is_mem,
  output logic [SEL_W-1:0]  sel,
  output reg_cls_e          rcls,
  output logic              is_f8
);

  localparam int MODE_HI = BYTE_W - 1;
  localparam int MODE_LO = BYTE_W - 2;

  always_comb begin
    is_mem = (modrm[MODE_HI:MODE_LO] != 2'b11);
    sel    = modrm[MODE_LO-1 -: SEL_W];
    is_f8  = (modrm == 8'hF8);
    rcls   = RF_RSV;
    if (!is_mem) begin
      unique case (sel)
        3'd5:    rcls = RF_LFENCE;
        3'd6:    rcls = RF_MFENCE;
        3'd7:    rcls = RF_SFENCE;
        default: rcls = RF_RSV;
      endcase
    end
  end

endmodule

// File: rtl/grp_mem_rules.sv
module grp_mem_rules
  import grp_dec_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             lock,
  input  logic             opsz,
  input  logic             rep_any,
  input  logic             ft_save,
  input  logic             ft_wback,
  input  logic             ft_flopt,
  input  logic             ft_flush,
  input  logic             emu,
  input  logic             ts,
  input  logic             xen,
  output dec_res_t         res
);

  always_comb begin
    res = '0;
    unique case (sel)
      3'd0, 3'd1: begin
        if (!ft_save || lock)      res.ud = 1'b1;
        else if (emu || ts)        res.nm = 1'b1;
        else if (sel == 3'd0)      res.op[OP_SAVE] = 1'b1;
        else                       res.op[OP_RESTORE] = 1'b1;
      end
      3'd2, 3'd3: begin
        if (emu || !xen)           res.ud = 1'b1;
        else if (ts)               res.nm = 1'b1;
        else if (sel == 3'd2)      res.op[OP_CSR_LD] = 1'b1;
        else                       res.op[OP_CSR_ST] = 1'b1;
      end
      3'd6: begin
        if (lock || !opsz || !ft_wback) res.ud = 1'b1;
        else                            res.op[OP_WBACK] = 1'b1;
      end
      3'd7: begin
        if (lock)                  res.ud = 1'b1;
        else if (opsz) begin
          if (!ft_flopt)           res.ud = 1'b1;
          else                     res.op[OP_FLOPT] = 1'b1;
        end else begin
          if (rep_any || !ft_flush) res.ud = 1'b1;
          else                      res.op[OP_FLUSH] = 1'b1;
        end
      end
      default:                     res.ud = 1'b1;
    endcase
    res.need_addr = |res.op;
  end

endmodule

// File: rtl/grp_reg_rules.sv
module grp_reg_rules
  import grp_dec_pkg::*;
(
  input  reg_cls_e  rcls,
  input  logic      is_f8,
  input  logic      lock,
  input  logic      opsz,
  input  logic      ft_commit,
  input  logic      ft_fence,
  output dec_res_t  res
);

  logic commit_form;
  logic fence_ok;

  always_comb begin
    commit_form = is_f8 && opsz;
    fence_ok    = ft_fence && !lock;
    res         = '0;
    if (commit_form) begin
      if (!ft_commit || lock) res.ud = 1'b1;
      else                    res.op[OP_COMMIT] = 1'b1;
    end else begin
      unique case (rcls)
        RF_LFENCE: if (fence_ok) res.op[OP_LFENCE] = 1'b1; else res.ud = 1'b1;
        RF_MFENCE: if (fence_ok) res.op[OP_MFENCE] = 1'b1; else res.ud = 1'b1;
        RF_SFENCE: if (fence_ok) res.op[OP_SFENCE] = 1'b1; else res.ud = 1'b1;
        default:   res.ud = 1'b1;
      endcase
    end
    res.need_addr = 1'b0;
  end

endmodule

// File: rtl/grp_out_stage.sv
module grp_out_stage
  import grp_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  dec_res_t d,
  output logic     q_valid,
  output dec_res_t q
);

  logic     valid_nxt;
  dec_res_t res_nxt;

  always_comb begin
    valid_nxt = en;
    res_nxt   = q;
    if (en) res_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= valid_nxt;
      q       <= res_nxt;
    end
  end

endmodule

// File: rtl/grp_legal_dec.sv
module grp_legal_dec
  import grp_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_modrm,
  input  logic [PFX_W-1:0]  in_pfx,
  input  logic [FEAT_W-1:0] in_feat,
  input  logic [CTL_W-1:0]  in_ctl,
  output logic              out_valid,
  output logic [OP_W-1:0]   out_op,
  output logic              out_need_addr,
  output logic              out_ud,
  output logic              out_nm
);

  logic             is_mem;
  logic [SEL_W-1:0] sel;
  reg_cls_e         rcls;
  logic             is_f8;
  dec_res_t         mem_res;
  dec_res_t         reg_res;
  dec_res_t         sel_res;
  dec_res_t         q_res;

  grp_form_split u_split (
    .modrm  (in_modrm),
    .is_mem (is_mem),
    .sel    (sel),
    .rcls   (rcls),
    .is_f8  (is_f8)
  );

  grp_mem_rules u_mem (
    .sel      (sel),
    .lock     (in_pfx[PFX_LOCK]),
    .opsz     (in_pfx[PFX_OPSZ]),
    .rep_any  (in_pfx[PFX_REP] | in_pfx[PFX_REPNE]),
    .ft_save  (in_feat[FT_SAVE]),
    .ft_wback (in_feat[FT_WBACK]),
    .ft_flopt (in_feat[FT_FLOPT]),
    .ft_flush (in_feat[FT_FLUSH]),
    .emu      (in_ctl[CT_EMU]),
    .ts       (in_ctl[CT_TS]),
    .xen      (in_ctl[CT_XEN]),
    .res      (mem_res)
  );

  grp_reg_rules u_reg (
    .rcls      (rcls),
    .is_f8     (is_f8),
    .lock      (in_pfx[PFX_LOCK]),
    .opsz      (in_pfx[PFX_OPSZ]),
    .ft_commit (in_feat[FT_COMMIT]),
    .ft_fence  (in_feat[FT_FENCE]),
    .res       (reg_res)
  );

  always_comb begin
    sel_res = is_mem ? mem_res : reg_res;
  end

  grp_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_valid),
    .d       (sel_res),
    .q_valid (out_valid),
    .q       (q_res)
  );

  assign out_op        = q_res.op;
  assign out_need_addr = q_res.need_addr;
  assign out_ud        = q_res.ud;
  assign out_nm        = q_res.nm;

endmodule

// File: rtl/grp_legal_dec_chk.sv
module grp_legal_dec_chk
  import grp_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_modrm,
  input logic [PFX_W-1:0]  in_pfx,
  input logic [FEAT_W-1:0] in_feat,
  input logic [CTL_W-1:0]  in_ctl,
  input logic              out_valid,
  input logic [OP_W-1:0]   out_op,
  input logic              out_need_addr,
  input logic              out_ud,
  input logic              out_nm
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_single_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!(out_ud && out_nm) && $onehot0(out_op)));

  assert_fault_clears_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_ud || out_nm)) |-> (out_op == '0 && !out_need_addr));

  assert_save_nm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_modrm[7:6] != 2'b11 && in_modrm[5:4] == 2'b00 &&
     in_feat[FT_SAVE] && !in_pfx[PFX_LOCK] && (in_ctl[CT_EMU] || in_ctl[CT_TS]))
    |=> (out_nm && !out_ud));

  assert_wback_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_modrm[7:6] != 2'b11 && in_modrm[5:3] == 3'd6 && in_pfx[PFX_LOCK])
    |=> out_ud);

  assert_fence_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_modrm >= 8'hE8 && !(in_modrm == 8'hF8 && in_pfx[PFX_OPSZ]) &&
     in_feat[FT_FENCE] && !in_pfx[PFX_LOCK])
    |=> (!out_ud && !out_nm && $countones(out_op) == 1));

  assert_reserved_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_modrm[7:6] == 2'b11 && in_modrm < 8'hE8) |=> out_ud);

  assert_addr_mem_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_need_addr) |-> ((out_op & MEM_OP_MASK) != '0));

endmodule

bind grp_legal_dec grp_legal_dec_chk u_chk (.*);

// File: tb/test_grp_legal_dec.sv
module test_grp_legal_dec;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_modrm;
  logic [3:0]  in_pfx;
  logic [5:0]  in_feat;
  logic [2:0]  in_ctl;
  logic        out_valid;
  logic [10:0] out_op;
  logic        out_need_addr;
  logic        out_ud;
  logic        out_nm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic        exp_valid;
  logic [10:0] exp_op;
  logic        exp_na, exp_ud, exp_nm;
  string       exp_tag;

  grp_legal_dec i_grp_legal_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_modrm(in_modrm),
    .in_pfx(in_pfx), .in_feat(in_feat), .in_ctl(in_ctl),
    .out_valid(out_valid), .out_op(out_op), .out_need_addr(out_need_addr),
    .out_ud(out_ud), .out_nm(out_nm)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference for one decode
  function automatic void ref_dec(input logic [7:0] m, input logic [3:0] p,
                                  input logic [5:0] f, input logic [2:0] c,
                                  output logic [10:0] op, output logic na,
                                  output logic ud, output logic nm,
                                  output string tag);
    int  kind = -1;
    bit  lock = p[0], opsz = p[1], reps = p[2] | p[3];
    bit  mem  = (m[7:6] != 2'b11);
    int  r    = m[5:3];
    ud = 0; nm = 0;
    if (mem) begin
      if (r == 0 || r == 1) begin
        tag = "R3";
        if (!f[0] || lock) ud = 1; else if (c[0] || c[1]) nm = 1; else kind = r;
      end else if (r == 2 || r == 3) begin
        tag = "R4";
        if (c[0] || !c[2]) ud = 1; else if (c[1]) nm = 1; else kind = r;
      end else if (r == 6) begin
        tag = "R5";
        if (lock || !opsz || !f[1]) ud = 1; else kind = 4;
      end else if (r == 7) begin
        tag = "R6";
        if (lock) ud = 1;
        else if (opsz) begin if (f[2]) kind = 6; else ud = 1; end
        else if (reps || !f[3]) ud = 1;
        else kind = 5;
      end else begin
        tag = "R9"; ud = 1;
      end
    end else if (m == 8'hF8 && opsz) begin
      tag = "R8";
      if (!f[4] || lock) ud = 1; else kind = 7;
    end else if (m >= 8'hE8) begin
      tag = "R7";
      if (!f[5] || lock) ud = 1;
      else if (m < 8'hF0) kind = 8;
      else if (m < 8'hF8) kind = 9;
      else kind = 10;
    end else begin
      tag = "R9"; ud = 1;
    end
    op = (kind >= 0) ? 11'(1 << kind) : 11'd0;
    na = (kind >= 0) && mem;
  endfunction

  task automatic check_now();
    total++;
    if (out_valid !== exp_valid) begin
      bad++;
      $display("FAIL R1: out_valid=%b expected %b", out_valid, exp_valid);
    end
    if (exp_valid) begin
      total++;
      if (out_op !== exp_op || out_ud !== exp_ud || out_nm !== exp_nm) begin
        bad++;
        $display("FAIL %s/R2: op=%h ud=%b nm=%b expected op=%h ud=%b nm=%b",
                 exp_tag, out_op, out_ud, out_nm, exp_op, exp_ud, exp_nm);
      end
      total++;
      if (out_need_addr !== exp_na) begin
        bad++;
        $display("FAIL R10 (%s): need_addr=%b expected %b", exp_tag, out_need_addr, exp_na);
      end
    end
  endtask

  // check the result of the previous request, then drive the next one
  task automatic step(input logic v, input logic [7:0] m, input logic [3:0] p,
                      input logic [5:0] f, input logic [2:0] c);
    @(negedge clk);
    check_now();
    in_valid = v; in_modrm = m; in_pfx = p; in_feat = f; in_ctl = c;
    exp_valid = v;
    if (v) ref_dec(m, p, f, c, exp_op, exp_na, exp_ud, exp_nm, exp_tag);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 0; in_modrm = 0; in_pfx = 0; in_feat = 0; in_ctl = 0;
    exp_valid = 0; exp_op = 0; exp_na = 0; exp_ud = 0; exp_nm = 0; exp_tag = "R1";
    in_valid = 1'b1; // a request during reset must not show
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 0 || out_op !== 0 || out_need_addr !== 0 || out_ud !== 0 || out_nm !== 0) begin
      bad++;
      $display("FAIL R1: reset outputs v=%b op=%h na=%b ud=%b nm=%b expected all 0",
               out_valid, out_op, out_need_addr, out_ud, out_nm);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    // every form byte with every prefix mix, all features, clean flags
    for (int m = 0; m < 256; m++)
      for (int p = 0; p < 16; p++)
        step(1'b1, 8'(m), 4'(p), 6'h3F, 3'b100);
    // every form byte with every control flag setting, with and without lock
    for (int m = 0; m < 256; m++)
      for (int c = 0; c < 8; c++) begin
        step(1'b1, 8'(m), 4'b0000, 6'h3F, 3'(c));
        step(1'b1, 8'(m), 4'b0001, 6'h3F, 3'(c));
      end
    // each feature off on its own
    for (int ft = 0; ft < 6; ft++)
      for (int m = 0; m < 256; m++) begin
        step(1'b1, 8'(m), 4'b0000, 6'h3F & ~(6'(1) << ft), 3'b100);
        step(1'b1, 8'(m), 4'b0010, 6'h3F & ~(6'(1) << ft), 3'b100);
      end
    // random mix with idle gaps
    for (int i = 0; i < 30000; i++)
      step(($urandom % 5) != 0, 8'($urandom), 4'($urandom), 6'($urandom), 3'($urandom));
    step(1'b0, 8'h00, 4'h0, 6'h00, 3'h0);
    step(1'b0, 8'h00, 4'h0, 6'h00, 3'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule